// File: doc/BRIEF.md
# Parallel Quasi-Cyclic LDPC Encoder

This block turns one information vector into one systematic codeword of a quasi-cyclic LDPC code. The generator's parity part is a K×C array of B×B circulants. Each circulant is fully defined by its first column, and these columns are supplied as a compile-time constant. Each information/parity block pair has its own B-bit rotating register. Every clock, each parity block combines its K registers with the latched information vector through AND gates and one wide XOR, and so yields one parity bit. All C parity blocks run side by side, so a codeword needs exactly B cycles whatever K and C are.

A start strobe seen while the encoder is idle latches the information vector and reloads every rotating register with its circulant's first column. After B cycles, done pulses for one cycle. valid then stays high, and the codeword stays on its output, until the next accepted start. While the encoder is running, the parity bits of the current column also appear on a narrow C-bit output.

Top module: `qc_ldpc_encoder`

## Requirements
- R1: While reset is asserted, and after it is released, busy_o, done_o and valid_o are 0 and codeword_o is all zeros. Reset asserts asynchronously and is released synchronously through a two-stage synchronizer.
- R2: A start_i sampled high at a rising edge while busy_o is 0 latches info_i. busy_o is 1 from the next cycle, and codeword_o[K*B-1:0] then equals the latched vector and holds steady until the next accepted start.
- R3: After an accepted start, busy_o stays high for exactly B cycles. done_o is high for exactly one cycle, the first cycle after busy_o falls.
- R4: The generator constant GEN stores circulant (info block j, parity block i) at bits GEN[(i*K+j)*B +: B], where bit r is row r of its column 0. The entry in row r and column t is GEN[(i*K+j)*B + ((r-t) mod B)]. Parity bit t of block i is the XOR over all j and r of info[j*B+r] AND that entry.
- R5: Codeword layout, LSB first: bits 0..K*B-1 are the information bits. Parity block i, bits t = 0..B-1, follows at index K*B + i*B + t.
- R6: In the t-th busy cycle after an accepted start (t = 0..B-1), parity_bit_o[i] equals parity bit t of block i.
- R7: Every finished codeword satisfies H·cᵀ = 0 over GF(2), with H = [Pᵀ | I].
- R8: A start_i asserted while busy_o is 1 is ignored. Neither the latched information, the parity result nor the done timing changes.
- R9: valid_o rises together with done_o, is 0 whenever busy_o is 1, and is cleared by the next accepted start. A start in the done cycle is accepted.

Parameters: B (circulant size, at least 2), K (information circulants), C (parity circulants), GEN (first columns, C*K*B bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start_i | input | 1 | Start strobe, honored only when idle |
| info_i | input | K*B | Information vector |
| busy_o | output | 1 | Encoding in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| valid_o | output | 1 | codeword_o holds a finished codeword |
| parity_bit_o | output | C | Parity bit of the current column, one per parity block |
| codeword_o | output | K*B+C*B | Systematic codeword |

## Verification
Two pairs of events can meet in one cycle. The first is a start with the last parity store, or with the done pulse that follows it. The second is a start with a running encode. The bench raises start in the exact cycle done_o is high. It expects that start to be accepted: valid_o falls, busy_o rises, and a fresh B-cycle encode of the new vector produces the right parity. It also raises start with a different vector halfway through an encode. There it expects no effect: the original information and its reference parity stay on codeword_o, and done lands B cycles after the first start.

// File: rtl/qc_ldpc_pkg.sv
package qc_ldpc_pkg;
  typedef enum logic {
    ENC_IDLE = 1'b0,
    ENC_RUN  = 1'b1
  } enc_state_e;
endpackage

// File: rtl/qc_gen_shreg.sv
module qc_gen_shreg #(
  parameter int unsigned B = 7,
  parameter logic [B-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  output logic [B-1:0] q_o
);
  logic [B-1:0] q_r, q_nx;

  // Rotation moves column t to column t+1 of the circulant.
  always_comb begin
    q_nx = q_r;
    if (load_i)       q_nx = INIT;
    else if (shift_i) q_nx = {q_r[B-2:0], q_r[B-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q_r <= INIT;
    else if (load_i || shift_i) q_r <= q_nx;
  end

  assign q_o = q_r;
endmodule

// File: rtl/qc_parity_lane.sv
module qc_parity_lane #(
  parameter int unsigned B = 7,
  parameter int unsigned K = 3,
  parameter logic [K*B-1:0] LANE_GEN = '0,
  localparam int unsigned KB = K * B,
  localparam int unsigned IW = $clog2(B)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [IW-1:0] idx_i,
  input  logic [KB-1:0] info_i,
  output logic          bit_o,
  output logic [B-1:0]  par_o
);
  logic [KB-1:0] col_all;
  logic [B-1:0]  par_r, par_nx;

  for (genvar j = 0; j < K; j++) begin : g_blk
    qc_gen_shreg #(
      .B   (B),
      .INIT(LANE_GEN[j*B +: B])
    ) u_shreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .shift_i(step_i),
      .q_o    (col_all[j*B +: B])
    );
  end

  // One AND per information bit, then a single wide XOR.
  assign bit_o = ^(info_i & col_all);

  always_comb begin
    par_nx = par_r;
    if (load_i)      par_nx = '0;
    else if (step_i) par_nx[idx_i] = bit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                par_r <= '0;
    else if (load_i || step_i) par_r <= par_nx;
  end

  assign par_o = par_r;
endmodule

// File: rtl/qc_enc_ctrl.sv
module qc_enc_ctrl
  import qc_ldpc_pkg::*;
#(
  parameter int unsigned B = 7,
  localparam int unsigned IW = $clog2(B)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          load_o,
  output logic          step_o,
  output logic [IW-1:0] idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          valid_o
);
  localparam logic [IW-1:0] LAST = IW'(B - 1);

  enc_state_e    st_r, st_nx;
  logic [IW-1:0] cnt_r, cnt_nx;
  logic          done_r, done_nx;
  logic          valid_r, valid_nx;
  logic          accept;

  assign accept = start_i && (st_r == ENC_IDLE);

  always_comb begin
    st_nx    = st_r;
    cnt_nx   = cnt_r;
    done_nx  = 1'b0;
    valid_nx = valid_r;
    if (accept) begin
      st_nx    = ENC_RUN;
      cnt_nx   = '0;
      valid_nx = 1'b0;
    end else if (st_r == ENC_RUN) begin
      if (cnt_r == LAST) begin
        st_nx    = ENC_IDLE;
        done_nx  = 1'b1;
        valid_nx = 1'b1;
      end else begin
        cnt_nx = cnt_r + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r    <= ENC_IDLE;
      cnt_r   <= '0;
      done_r  <= 1'b0;
      valid_r <= 1'b0;
    end else begin
      st_r    <= st_nx;
      cnt_r   <= cnt_nx;
      done_r  <= done_nx;
      valid_r <= valid_nx;
    end
  end

  assign load_o  = accept;
  assign step_o  = (st_r == ENC_RUN);
  assign idx_o   = cnt_r;
  assign busy_o  = (st_r == ENC_RUN);
  assign done_o  = done_r;
  assign valid_o = valid_r;
endmodule

// File: rtl/qc_ldpc_encoder.sv
module qc_ldpc_encoder #(
  parameter int unsigned B = 7,
  parameter int unsigned K = 3,
  parameter int unsigned C = 2,
  parameter logic [C*K*B-1:0] GEN = 42'h2A5_3C9E_6B27,
  localparam int unsigned KB = K * B,
  localparam int unsigned NW = K * B + C * B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [KB-1:0] info_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          valid_o,
  output logic [C-1:0]  parity_bit_o,
  output logic [NW-1:0] codeword_o
);
  localparam int unsigned IW = $clog2(B);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            load, step;
  logic [IW-1:0]   idx;
  logic [KB-1:0]   info_r, info_nx;
  logic [C*B-1:0]  par_all;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  qc_enc_ctrl #(.B(B)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .idx_o  (idx),
    .busy_o (busy_o),
    .done_o (done_o),
    .valid_o(valid_o)
  );

  always_comb begin
    info_nx = info_r;
    if (load) info_nx = info_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) info_r <= '0;
    else if (load)  info_r <= info_nx;
  end

  for (genvar i = 0; i < C; i++) begin : g_lane
    qc_parity_lane #(
      .B       (B),
      .K       (K),
      .LANE_GEN(GEN[i*KB +: KB])
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_int_n),
      .load_i(load),
      .step_i(step),
      .idx_i (idx),
      .info_i(info_r),
      .bit_o (parity_bit_o[i]),
      .par_o (par_all[i*B +: B])
    );
  end

  assign codeword_o = {par_all, info_r};
endmodule

// File: rtl/qc_ldpc_encoder_chk.sv
module qc_ldpc_encoder_chk #(
  parameter int unsigned B = 7,
  parameter int unsigned K = 3,
  parameter int unsigned C = 2,
  localparam int unsigned KB = K * B,
  localparam int unsigned NW = K * B + C * B
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          valid_o,
  input logic [NW-1:0] codeword_o
);
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_info_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(codeword_o[KB-1:0]));

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_cnt == B));

  assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < B));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (valid_o && !busy_o));

  assert_no_valid_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !valid_o);
endmodule

bind qc_ldpc_encoder qc_ldpc_encoder_chk #(.B(B), .K(K), .C(C)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .valid_o   (valid_o),
  .codeword_o(codeword_o)
);

// File: tb/tb_qc_ldpc_encoder.sv
`timescale 1ns/1ps
module tb_qc_ldpc_encoder;
  localparam int unsigned B  = 7;
  localparam int unsigned K  = 3;
  localparam int unsigned C  = 2;
  localparam int unsigned KB = K * B;
  localparam int unsigned NW = K * B + C * B;
  localparam logic [C*K*B-1:0] GEN = 42'h2A5_3C9E_6B27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [KB-1:0] info_i = '0;
  logic          busy_o, done_o, valid_o;
  logic [C-1:0]  parity_bit_o;
  logic [NW-1:0] codeword_o;

  int n_chk = 0;
  int n_bad = 0;

  qc_ldpc_encoder #(.B(B), .K(K), .C(C), .GEN(GEN)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .info_i      (info_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .valid_o     (valid_o),
    .parity_bit_o(parity_bit_o),
    .codeword_o  (codeword_o)
  );

  always #10 clk = ~clk;

  // Circulant entry at row r, column t of block (j, i).
  function automatic logic circ(int i, int j, int r, int t);
    int idx = ((r - t) % int'(B) + int'(B)) % int'(B);
    return GEN[(i*K + j)*B + idx];
  endfunction

  function automatic logic ref_bit(logic [KB-1:0] u, int i, int t);
    logic acc = 1'b0;
    for (int j = 0; j < K; j++)
      for (int r = 0; r < B; r++)
        acc ^= u[j*B + r] & circ(i, j, r, t);
    return acc;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_codeword(logic [KB-1:0] u, string tag);
    logic [C*B-1:0] exp_par;
    logic           syn_ok = 1'b1;
    for (int i = 0; i < C; i++)
      for (int t = 0; t < B; t++)
        exp_par[i*B + t] = ref_bit(u, i, t);
    check(codeword_o[KB-1:0] == u, "R5", {tag, " info field"},
          64'(codeword_o[KB-1:0]), 64'(u));
    check(codeword_o[NW-1:KB] == exp_par, "R4", {tag, " parity field"},
          64'(codeword_o[NW-1:KB]), 64'(exp_par));
    // R7: H = [P^T | I], syndrome over codeword taken from the port.
    for (int i = 0; i < C; i++)
      for (int t = 0; t < B; t++) begin
        logic s = codeword_o[KB + i*B + t];
        for (int j = 0; j < K; j++)
          for (int r = 0; r < B; r++)
            s ^= codeword_o[j*B + r] & circ(i, j, r, t);
        if (s) syn_ok = 1'b0;
      end
    check(syn_ok, "R7", {tag, " syndrome zero"}, 64'(!syn_ok), 64'd0);
  endtask

  // Issues a start at the next negedge; returns in busy cycle 0.
  task automatic pulse_start(logic [KB-1:0] u);
    start_i = 1'b1;
    info_i  = u;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // From busy cycle 0, walks the run and checks the done cycle; ends there.
  task automatic run_and_check(logic [KB-1:0] u, string tag, int mid_start, logic [KB-1:0] other);
    for (int t = 0; t < B; t++) begin
      logic [C-1:0] exp_pb;
      for (int i = 0; i < C; i++) exp_pb[i] = ref_bit(u, i, t);
      check(busy_o && !done_o, "R3", {tag, " busy in run"}, 64'({busy_o, done_o}), 64'b10);
      check(!valid_o, "R9", {tag, " valid low while busy"}, 64'(valid_o), 64'd0);
      check(parity_bit_o == exp_pb, "R6", {tag, " column parity"}, 64'(parity_bit_o), 64'(exp_pb));
      check(codeword_o[KB-1:0] == u, "R2", {tag, " latched info"}, 64'(codeword_o[KB-1:0]), 64'(u));
      if (t == mid_start) begin start_i = 1'b1; info_i = other; end
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(!busy_o && done_o && valid_o, "R3", {tag, " done cycle"},
          64'({busy_o, done_o, valid_o}), 64'b011);
    check_codeword(u, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !valid_o, "R1", "in reset flags", 64'({busy_o, done_o, valid_o}), 64'd0);
    check(codeword_o == '0, "R1", "in reset codeword", 64'(codeword_o), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !valid_o, "R1", "after release flags", 64'({busy_o, done_o, valid_o}), 64'd0);
  endtask

  task automatic t_basic(logic [KB-1:0] u, string tag);
    pulse_start(u);
    run_and_check(u, tag, -1, '0);
    @(negedge clk);
    check(!done_o && valid_o, "R9", {tag, " done single, valid held"}, 64'({done_o, valid_o}), 64'b01);
    info_i = ~u;
    repeat (2) @(negedge clk);
    check(codeword_o[KB-1:0] == u && !busy_o, "R2", {tag, " info held while idle"},
          64'(codeword_o[KB-1:0]), 64'(u));
  endtask

  task automatic t_start_while_busy();
    logic [KB-1:0] u = 21'h0B3C5;
    pulse_start(u);
    run_and_check(u, "mid-run start", 3, 21'h1F0F0);
    @(negedge clk);
    check(!busy_o && valid_o, "R8", "no restart after ignored start", 64'({busy_o, valid_o}), 64'b01);
  endtask

  task automatic t_start_in_done();
    logic [KB-1:0] u1 = 21'h12345;
    logic [KB-1:0] u2 = 21'h0ACE1;
    pulse_start(u1);
    run_and_check(u1, "first of pair", -1, '0);
    // Now in the done cycle: raise start here.
    pulse_start(u2);
    check(busy_o && !valid_o && !done_o, "R9", "start in done cycle accepted",
          64'({busy_o, valid_o, done_o}), 64'b100);
    run_and_check(u2, "second of pair", -1, '0);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic('0, "zeros");
    t_basic('1, "ones");
    for (int b = 0; b < KB; b += 5) t_basic(KB'(1) << b, "single bit");
    for (int n = 0; n < 6; n++) t_basic(KB'($urandom), "random");
    t_start_while_busy();
    t_start_in_done();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule